// File: doc/BRIEF.md
# Bit-Serial Jitter Attenuation Buffer

This block is a one-bit-wide elastic store that sits between a jittery recovered-clock domain and a smoothed output. Incoming bits arrive on write strobes that follow the irregular recovered clock. They leave on read strobes produced by a phase-accumulator oscillator. A proportional loop filter steers that oscillator by driving the fill level towards half the active depth. All logic runs on one system clock and uses enables.

The buffer can be 32 or 64 bits deep. The loop bandwidth depends on the line standard. T1 has one fixed narrow setting. E1 offers a wider and a narrower setting, and the narrower one always uses the 64-bit depth. When the fill level comes within two bits of empty or full, the loop switches to a wide tracking bandwidth so that the read clock can follow short-term input jitter. It stays there until the fill level moves back out of that band. Reading starts only after half the depth has been filled. Sticky flags record any write that is lost or any read that finds the store empty.

Top module: `jbuf_top`

## Requirements
- R1: The effective depth D is 64 when `deep_sel`=1 or when (`mode_e1`=1 and `bw_narrow`=1), and 32 otherwise. `depth64` shows the effective depth one cycle later (1 means 64).
- R2: When `mode_e1`=0 (T1), `bw_narrow` has no effect on depth, strobe timing or data.
- R3: After reset or after any change of D, the store restarts empty. `rd_stb` stays 0 and `rd_bit` stays 0 until the fill level reaches D/2. `primed` is set in the cycle after that fill level is reached.
- R4: Bits leave in the order they were written, each bit exactly once. `rd_bit` holds the last bit that was read.
- R5: Once primed, an accumulator of ACC_W bits adds the increment on every clock. `rd_stb` pulses for one cycle, in the cycle after each carry out of the accumulator.
- R6: The increment is NOM + ((fill − D/2)·2^GAIN) arithmetically right-shifted by the selected shift, rounding toward minus infinity. NOM is NOM_T1 in T1 and NOM_E1 in E1.
- R7: The shift is SH_T1 in T1, SH_E1W for E1 with `bw_narrow`=0, and SH_E1N for E1 with `bw_narrow`=1. While `guard_active`=1 it is SH_GUARD instead.
- R8: `guard_active` is 1 exactly while the store is primed and the fill level is ≤ 2 or ≥ D−2. It clears as soon as the fill level leaves that band.
- R9: A write strobe that arrives when the store is full and no read happens in the same cycle is dropped, and `ovf_flag` is set. The fill level never exceeds D.
- R10: A read event on an empty store still pulses `rd_stb`, moves no data, keeps `rd_bit` unchanged and sets `udf_flag`.
- R11: `clr_flags` clears both sticky flags. An event in the same cycle wins over the clear.
- R12: When a read and a write happen together on a full store, the read returns the oldest bit and the write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write enable from the recovered clock |
| wr_bit | input | 1 | Data bit written on `wr_stb` |
| mode_e1 | input | 1 | 1 = E1 rate and bandwidths, 0 = T1 |
| bw_narrow | input | 1 | E1 only: 1 = narrower bandwidth |
| deep_sel | input | 1 | 1 = request 64-bit depth |
| clr_flags | input | 1 | Clears the sticky flags |
| rd_stb | output | 1 | Smoothed read strobe |
| rd_bit | output | 1 | Data bit of the last read |
| depth64 | output | 1 | Active depth is 64 |
| primed | output | 1 | Half-depth fill reached, reading enabled |
| guard_active | output | 1 | Wide tracking bandwidth in force |
| ovf_flag | output | 1 | Sticky: a write was lost |
| udf_flag | output | 1 | Sticky: a read found the store empty |

## Verification
The main function is driven with three kinds of write cadence, and each one separates different faults. Jittered cadences around the T1 and E1 nominal rates confirm that the proportional loop, the shift selection and the FIFO ordering track an exact reference cycle by cycle. A back-to-back burst pushes the store to full, which exposes dropped-write handling, the guard bandwidth and the read-first behaviour on a full store. A long starvation drains the store, which exposes underflow handling. Depth and mode changes in the middle of a run show whether a restart is triggered only by a real change of the effective depth and never by `bw_narrow` alone in T1.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;
  // loop bandwidth selection, priority: guard > standard-specific setting
  typedef enum logic [1:0] {
    BW_T1        = 2'd0,
    BW_E1_WIDE   = 2'd1,
    BW_E1_NARROW = 2'd2,
    BW_GUARD     = 2'd3
  } bw_sel_e;
endpackage

// File: rtl/jbuf_ram.sv
module jbuf_ram #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              q_clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic              wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic              q
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read-first registered output (R12)
  always_ff @(posedge clk) begin
    if (q_clr)   q <= 1'b0;
    else if (re) q <= mem[ra];
  end
endmodule

// File: rtl/jbuf_loop.sv
module jbuf_loop
  import jbuf_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int ACC_W    = 16,
  parameter int GAIN     = 8,
  parameter int NOM_T1   = 8192,
  parameter int NOM_E1   = 10923,
  parameter int SH_T1    = 5,
  parameter int SH_E1W   = 3,
  parameter int SH_E1N   = 6,
  parameter int SH_GUARD = 1
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] half,
  input  logic             mode_e1,
  input  logic             bw_narrow,
  input  logic             guard,
  output logic [ACC_W-1:0] inc
);
  localparam int EXT_W = ACC_W + 2;

  bw_sel_e                 bw;
  logic [4:0]              shamt;
  logic signed [CNT_W:0]   err;
  logic signed [EXT_W-1:0] err_w, adj, nom, total;

  always_comb begin
    // R2/R7: T1 ignores bw_narrow; guard overrides everything
    if (guard)          bw = BW_GUARD;
    else if (!mode_e1)  bw = BW_T1;
    else if (bw_narrow) bw = BW_E1_NARROW;
    else                bw = BW_E1_WIDE;

    case (bw)
      BW_T1:        shamt = 5'(SH_T1);
      BW_E1_WIDE:   shamt = 5'(SH_E1W);
      BW_E1_NARROW: shamt = 5'(SH_E1N);
      default:      shamt = 5'(SH_GUARD);
    endcase

    // R6: proportional correction of the nominal increment
    err   = $signed({1'b0, fill}) - $signed({1'b0, half});
    err_w = EXT_W'(err);
    adj   = (err_w <<< GAIN) >>> shamt;
    nom   = mode_e1 ? EXT_W'(NOM_E1) : EXT_W'(NOM_T1);
    total = nom + adj;
    inc   = total[ACC_W-1:0];
  end
endmodule

// File: rtl/jbuf_nco.sv
module jbuf_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             wrap
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc} + {1'b0, inc};
    wrap = run & sum[ACC_W];           // R5: carry out gives a read event
  end

  always_ff @(posedge clk) begin
    if (rst || !run) acc <= '0;
    else             acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/jbuf_top.sv
module jbuf_top #(
  parameter int DEPTH_MAX = 64,
  parameter int DEPTH_MIN = 32,
  parameter int GUARD     = 2,
  parameter int ACC_W     = 16,
  parameter int GAIN      = 8,
  parameter int NOM_T1    = 8192,
  parameter int NOM_E1    = 10923,
  parameter int SH_T1     = 5,
  parameter int SH_E1W    = 3,
  parameter int SH_E1N    = 6,
  parameter int SH_GUARD  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic mode_e1,
  input  logic bw_narrow,
  input  logic deep_sel,
  input  logic clr_flags,
  output logic rd_stb,
  output logic rd_bit,
  output logic depth64,
  output logic primed,
  output logic guard_active,
  output logic ovf_flag,
  output logic udf_flag
);
  localparam int ADDR_W = $clog2(DEPTH_MAX);
  localparam int CNT_W  = ADDR_W + 1;

  logic [CNT_W-1:0]  depth_now, depth_q, half, fill_q, fill_nx;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, last_idx;
  logic [ACC_W-1:0]  inc;
  logic              restart, run, wrap, rd_evt, do_rd, do_wr;
  logic              ovf_evt, udf_evt, primed_nx;

  // R1: narrow E1 bandwidth forces the deep store
  always_comb begin
    depth_now = (deep_sel || (mode_e1 && bw_narrow)) ? CNT_W'(DEPTH_MAX)
                                                     : CNT_W'(DEPTH_MIN);
    restart   = (depth_now != depth_q);
    half      = depth_q >> 1;
    last_idx  = ADDR_W'(depth_q - 1'b1);
    run       = primed & ~restart;
    rd_evt    = wrap;
    do_rd     = rd_evt && (fill_q != '0);
    do_wr     = wr_stb && !restart && ((fill_q != depth_q) || do_rd);
    ovf_evt   = wr_stb && !restart && (fill_q == depth_q) && !do_rd;   // R9
    udf_evt   = rd_evt && (fill_q == '0);                              // R10
    fill_nx   = fill_q + CNT_W'(do_wr) - CNT_W'(do_rd);
    primed_nx = primed | (fill_nx >= half);                            // R3
  end

  jbuf_loop #(
    .CNT_W(CNT_W), .ACC_W(ACC_W), .GAIN(GAIN),
    .NOM_T1(NOM_T1), .NOM_E1(NOM_E1),
    .SH_T1(SH_T1), .SH_E1W(SH_E1W), .SH_E1N(SH_E1N), .SH_GUARD(SH_GUARD)
  ) loop_i (
    .fill(fill_q), .half(half), .mode_e1(mode_e1), .bw_narrow(bw_narrow),
    .guard(guard_active), .inc(inc)
  );

  jbuf_nco #(.ACC_W(ACC_W)) nco_i (
    .clk(clk), .rst(rst), .run(run), .inc(inc), .wrap(wrap)
  );

  jbuf_ram #(.DEPTH(DEPTH_MAX), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .q_clr(rst | restart),
    .we(do_wr), .wa(wr_ptr), .wd(wr_bit),
    .re(do_rd), .ra(rd_ptr), .q(rd_bit)
  );

  always_ff @(posedge clk) begin
    depth_q <= depth_now;
    if (rst || restart) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      fill_q       <= '0;
      primed       <= 1'b0;
      rd_stb       <= 1'b0;
      guard_active <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + 1'b1;
      fill_q       <= fill_nx;
      primed       <= primed_nx;
      rd_stb       <= rd_evt;
      // R8: guard band around empty and full
      guard_active <= primed_nx && ((fill_nx <= CNT_W'(GUARD)) ||
                                    (fill_nx >= depth_q - CNT_W'(GUARD)));
    end
  end

  // R11: sticky flags, a new event wins over the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag & ~clr_flags) | ovf_evt;
      udf_flag <= (udf_flag & ~clr_flags) | udf_evt;
    end
  end

  assign depth64 = (depth_q == CNT_W'(DEPTH_MAX));
endmodule

// File: rtl/jbuf_chk.sv
module jbuf_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             mode_e1,
  input logic             bw_narrow,
  input logic             clr_flags,
  input logic             rd_stb,
  input logic             primed,
  input logic             depth64,
  input logic             guard_active,
  input logic             ovf_flag,
  input logic             udf_flag,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] depth
);
  assert_no_read_unprimed_R3: assert property (@(posedge clk) disable iff (rst)
    !primed |-> !rd_stb);

  assert_narrow_forces_deep_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_e1 && bw_narrow) |=> depth64);

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill <= depth);

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(wr_stb));

  assert_guard_needs_prime_R8: assert property (@(posedge clk) disable iff (rst)
    guard_active |-> primed);

  assert_udf_with_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(udf_flag) |-> rd_stb);

  assert_clear_ovf_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_flags) && !$past(wr_stb)) |-> !ovf_flag);
endmodule

bind jbuf_top jbuf_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .mode_e1(mode_e1),
  .bw_narrow(bw_narrow), .clr_flags(clr_flags), .rd_stb(rd_stb),
  .primed(primed), .depth64(depth64), .guard_active(guard_active),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag), .fill(fill_q), .depth(depth_q)
);

// File: tb/jbuf_top_tb_top.sv
module jbuf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DMAX = 64, DMIN = 32, GUARD = 2, ACC_W = 16, GAIN = 8;
  localparam int NOM_T1 = 8192, NOM_E1 = 10923;
  localparam int SH_T1 = 5, SH_E1W = 3, SH_E1N = 6, SH_GUARD = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, wr_bit = 1'b0, mode_e1 = 1'b0, bw_narrow = 1'b0;
  logic deep_sel = 1'b0, clr_flags = 1'b0;
  logic rd_stb, rd_bit, depth64, primed, guard_active, ovf_flag, udf_flag;

  int n_chk = 0, n_fail = 0, cyc = 0, full_rd_seen = 0, guard_seen = 0;
  bit started = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jbuf_top #(
    .DEPTH_MAX(DMAX), .DEPTH_MIN(DMIN), .GUARD(GUARD), .ACC_W(ACC_W), .GAIN(GAIN),
    .NOM_T1(NOM_T1), .NOM_E1(NOM_E1), .SH_T1(SH_T1), .SH_E1W(SH_E1W),
    .SH_E1N(SH_E1N), .SH_GUARD(SH_GUARD)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_bit(wr_bit), .mode_e1(mode_e1),
    .bw_narrow(bw_narrow), .deep_sel(deep_sel), .clr_flags(clr_flags),
    .rd_stb(rd_stb), .rd_bit(rd_bit), .depth64(depth64), .primed(primed),
    .guard_active(guard_active), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit m_q[$];
  int m_fill = 0, m_D = DMIN, m_acc = 0;
  bit m_primed = 0, m_stb = 0, m_bit = 0, m_guard = 0, m_ovf = 0, m_udf = 0;

  function automatic int want_depth();
    return (deep_sel || (mode_e1 && bw_narrow)) ? DMAX : DMIN;
  endfunction

  always @(posedge clk) begin
    int cd, sh, inc, sum;
    bit evt, rd, wr, ovf, udf;
    cyc++;
    started = 1;
    cd = want_depth();
    if (rst) begin
      m_D = cd; m_q.delete(); m_fill = 0; m_acc = 0;
      m_primed = 0; m_stb = 0; m_bit = 0; m_guard = 0; m_ovf = 0; m_udf = 0;
    end else if (cd != m_D) begin
      m_D = cd; m_q.delete(); m_fill = 0; m_acc = 0;
      m_primed = 0; m_stb = 0; m_bit = 0; m_guard = 0;
      if (clr_flags) begin m_ovf = 0; m_udf = 0; end
    end else begin
      sh  = m_guard ? SH_GUARD : (!mode_e1 ? SH_T1 : (bw_narrow ? SH_E1N : SH_E1W));
      inc = (mode_e1 ? NOM_E1 : NOM_T1) + (((m_fill - m_D/2) * (1 << GAIN)) >>> sh);
      evt = 0;
      if (m_primed) begin
        sum   = m_acc + inc;
        evt   = (sum >= (1 << ACC_W));
        m_acc = sum % (1 << ACC_W);
      end else m_acc = 0;
      rd  = evt && (m_fill > 0);
      udf = evt && (m_fill == 0);
      wr  = wr_stb && ((m_fill < m_D) || rd);
      ovf = wr_stb && (m_fill == m_D) && !rd;
      if (rd && wr && m_fill == m_D) full_rd_seen++;
      if (rd) m_bit = m_q.pop_front();
      if (wr) m_q.push_back(wr_bit);
      m_fill = m_q.size();
      m_stb  = evt;
      if (!m_primed && m_fill >= m_D/2) m_primed = 1;
      m_guard = m_primed && ((m_fill <= GUARD) || (m_fill >= m_D - GUARD));
      m_ovf = (m_ovf && !clr_flags) || ovf;
      m_udf = (m_udf && !clr_flags) || udf;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R5 R6 R7 rd_stb", rd_stb, m_stb);
      chk("R4 R12 rd_bit", rd_bit, m_bit);
      chk("R1 depth64", depth64, m_D == DMAX);
      chk("R3 primed", primed, m_primed);
      chk("R8 guard_active", guard_active, m_guard);
      chk("R9 R11 ovf_flag", ovf_flag, m_ovf);
      chk("R10 R11 udf_flag", udf_flag, m_udf);
      if (guard_active) guard_seen++;
    end
  end

  // ---------------- stimulus ----------------
  int gaps_t1[5] = '{6, 10, 7, 9, 8};
  int gaps_e1[5] = '{4, 8, 5, 7, 6};
  logic [15:0] lfsr = 16'hACE1;

  // pat: 0 = jittered T1 cadence, 1 = jittered E1 cadence, 2 = burst, 3 = starve
  task automatic drive(int n, int pat);
    int cd = 1, gi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clr_flags = 1'b0;
      case (pat)
        0, 1: begin
          cd--;
          wr_stb = (cd == 0);
          if (cd == 0) begin
            cd = (pat == 0) ? gaps_t1[gi] : gaps_e1[gi];
            gi = (gi + 1) % 5;
          end
        end
        2: wr_stb = 1'b1;
        default: wr_stb = 1'b0;
      endcase
      if (wr_stb) begin
        lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_bit = lfsr[0];
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    chk("R3 reset rd_stb", rd_stb, 0);
    chk("R3 reset primed", primed, 0);
    chk("R9 reset ovf_flag", ovf_flag, 0);
    chk("R1 reset depth64", depth64, 0);
    rst = 1'b0;

    drive(3000, 0);                        // T1, 32 deep
    chk("R3 primed after fill", primed, 1);

    bw_narrow = 1'b1;                      // R2: no effect in T1
    drive(1000, 0);
    chk("R2 depth64 in T1", depth64, 0);
    chk("R2 no restart in T1", primed, 1);

    mode_e1 = 1'b1; bw_narrow = 1'b0;      // E1 wide, still 32 deep
    drive(3000, 1);

    bw_narrow = 1'b1;                      // R1: narrow forces 64
    drive(3000, 1);
    chk("R1 narrow forces deep", depth64, 1);

    drive(300, 2);                         // burst to full
    chk("R9 overflow flagged", ovf_flag, 1);
    chk("R8 guard entered", guard_seen > 0, 1);

    @(negedge clk); wr_stb = 1'b0; clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    chk("R11 clear ovf_flag", ovf_flag, 0);

    drive(800, 3);                         // starve
    chk("R10 underflow flagged", udf_flag, 1);

    mode_e1 = 1'b0; bw_narrow = 1'b0; deep_sel = 1'b1;  // T1 deep, no restart
    drive(2000, 0);
    deep_sel = 1'b0;                       // depth change -> restart
    drive(1500, 0);
    chk("R12 full read-write seen", full_rd_seen > 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule